// File: doc/BRIEF.md
# Two-Wire Bus Misplaced-Condition Guard

This block watches the synchronised clock and data samples of a two-wire serial bus. It flags any START or STOP condition that arrives while a byte or its acknowledge slot is in progress. It sits beside the byte shift logic, which supplies a frame-active indication and a count of the clock pulses seen in the current nine-bit slot. A START is a fall on the data sample while the clock sample stays high. A STOP is a rise on the data sample while the clock sample stays high. Each is judged from one pair of consecutive samples.

When the block finds a misplaced condition, it raises the interrupt flag and reports status code 0x00. While the fault stands, it holds the shift logic and tells the pad drivers to let both lines float. To recover, software writes the stop-request bit and the flag-clear bit together. The block then clears the fault and the stop-request bit and pulses a return to the idle, unaddressed slave state. It never emits a STOP onto the bus. When no fault is pending, the status reads 0xF8, which means no information is available.

Top module: `i2c_bus_fault_guard`

## Requirements
- R1: A START (data sample 1 then 0 while the clock sample is 1 in both cycles) with `frame_on`=1 and `bit_pos`≠0 sets `fault_flag` at the next clock edge, and `status_code` then reads 0x00.
- R2: A STOP (data sample 0 then 1 while the clock sample is 1 in both cycles) with `frame_on`=1 and `bit_pos`≠0 sets `fault_flag` at the next clock edge. This includes `bit_pos`=8, the acknowledge slot.
- R3: A START or STOP seen while `frame_on`=0, or while `bit_pos`=0 (byte boundary, before the first clock of the next slot), leaves `fault_flag` at 0 and `status_code` at 0xF8.
- R4: After reset, and whenever no fault is pending, the outputs read as follows: `fault_flag`=0, `status_code`=0xF8, `line_release`=0, `shift_hold`=0 and `go_idle`=0. Reset also clears `sto_req` and `ack_en`.
- R5: A write with `host_sto`=1 and `host_clr`=1 while a fault is pending clears `fault_flag` and `sto_req` at the next edge, and pulses `go_idle` high for exactly one cycle.
- R6: On every write, `ack_en` takes `host_ack`, and this includes the recovery write. Recovery changes no bit other than the fault and the stop request.
- R7: While a fault is pending, `line_release` and `shift_hold` are both 1. Otherwise both are 0.
- R8: While a fault is pending, a write that lacks either `host_sto` or `host_clr` leaves the fault in place. A write of `host_sto` alone is stored in `sto_req`.
- R9: Data-sample changes while the clock sample is low, and clock-sample edges on their own, never raise a fault.
- R10: A write with `host_sto`=1 while no fault is pending sets `sto_req`, which stays set without a `go_idle` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| scl_s | input | 1 | Synchronised clock-line sample |
| sda_s | input | 1 | Synchronised data-line sample |
| frame_on | input | 1 | A transfer is in progress |
| bit_pos | input | CNT_W | Clock pulses begun in the current nine-bit slot, 0 at a byte boundary |
| host_we | input | 1 | Host control write strobe |
| host_sto | input | 1 | Write data: stop-request bit |
| host_clr | input | 1 | Write data: flag-clear bit (write one to clear) |
| host_ack | input | 1 | Write data: acknowledge-enable bit |
| fault_flag | output | 1 | Interrupt flag raised by a misplaced condition |
| status_code | output | 8 | 0x00 with a fault pending, 0xF8 otherwise |
| sto_req | output | 1 | Stored stop-request bit |
| ack_en | output | 1 | Stored acknowledge-enable bit |
| line_release | output | 1 | Both lines must float |
| shift_hold | output | 1 | Shift logic must stop |
| go_idle | output | 1 | One-cycle return to the idle unaddressed slave state |

## Verification
The hardest case to reach is a fault that arrives while a stop request is already stored from an earlier write. The recovery write must then clear both together, and it must not be taken as an ordinary stop. The stimulus table reaches this by first storing a stop request with no fault pending. It then steps the clock sample high, drops the data sample mid-byte, and issues the combined write. Byte-boundary START and STOP conditions are also reached in the same walk, by clocking the lines with `bit_pos` held at 0.

// File: rtl/i2c_bus_fault_guard.sv
module i2c_bus_fault_guard #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_s,
  input  logic             sda_s,
  input  logic             frame_on,
  input  logic [CNT_W-1:0] bit_pos,
  input  logic             host_we,
  input  logic             host_sto,
  input  logic             host_clr,
  input  logic             host_ack,
  output logic             fault_flag,
  output logic [7:0]       status_code,
  output logic             sto_req,
  output logic             ack_en,
  output logic             line_release,
  output logic             shift_hold,
  output logic             go_idle
);
  localparam logic [7:0] CODE_FAULT = 8'h00;
  localparam logic [7:0] CODE_NONE  = 8'hF8;

  logic scl_q, sda_q;
  logic cond_seen, misplaced, recover;

  assign cond_seen = scl_s && scl_q && (sda_s != sda_q);
  assign misplaced = cond_seen && frame_on && (bit_pos != '0);
  assign recover   = fault_flag && host_we && host_sto && host_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q      <= 1'b1;
      sda_q      <= 1'b1;
      fault_flag <= 1'b0;
      sto_req    <= 1'b0;
      ack_en     <= 1'b0;
      go_idle    <= 1'b0;
    end else begin
      scl_q   <= scl_s;
      sda_q   <= sda_s;
      go_idle <= recover;
      if (recover)
        fault_flag <= 1'b0;
      else if (misplaced)
        fault_flag <= 1'b1;
      if (host_we) begin
        ack_en  <= host_ack;
        sto_req <= host_sto && !recover;
      end
    end
  end

  assign status_code  = fault_flag ? CODE_FAULT : CODE_NONE;
  assign line_release = fault_flag;
  assign shift_hold   = fault_flag;

  p_misplaced_flags_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (misplaced && !recover) |=> (fault_flag && status_code == CODE_FAULT));

  p_boundary_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!fault_flag && !(frame_on && bit_pos != '0)) |=> !fault_flag);

  p_recover_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_flag && host_we && host_sto && host_clr) |=> (!fault_flag && !sto_req && go_idle));

  p_idle_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    go_idle |=> !go_idle);

  p_ack_follows_r6: assert property (@(posedge clk) disable iff (!rst_n)
    host_we |=> (ack_en == $past(host_ack)));

  p_fault_sticks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_flag && !(host_we && host_sto && host_clr)) |=> fault_flag);

  p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_flag) |-> (line_release && shift_hold));
endmodule

// File: tb/i2c_bus_fault_guard_test.sv
`timescale 1ns/1ps
module i2c_bus_fault_guard_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_s = 1'b1, sda_s = 1'b1, frame_on = 1'b0;
  logic [3:0] bit_pos = '0;
  logic host_we = 1'b0, host_sto = 1'b0, host_clr = 1'b0, host_ack = 1'b0;
  logic fault_flag, sto_req, ack_en, line_release, shift_hold, go_idle;
  logic [7:0] status_code;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  i2c_bus_fault_guard #(.CNT_W(4)) uut (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s), .frame_on(frame_on),
    .bit_pos(bit_pos), .host_we(host_we), .host_sto(host_sto), .host_clr(host_clr),
    .host_ack(host_ack), .fault_flag(fault_flag), .status_code(status_code),
    .sto_req(sto_req), .ack_en(ack_en), .line_release(line_release),
    .shift_hold(shift_hold), .go_idle(go_idle));

  // {req[3:0], scl, sda, frame_on, bit_pos[3:0], we, sto, clr, ack, exp_fault, exp_sto, exp_ack, exp_idle}
  localparam int NV = 23;
  localparam logic [18:0] VEC [NV] = '{
    19'b0100_110_0000_0000_0000, // R4 idle
    19'b0011_100_0000_0000_0000, // R3 START, no frame
    19'b0011_001_0000_0000_0000, // R3 clock low, boundary
    19'b1001_011_0011_0000_0000, // R9 data rises, clock low
    19'b1001_111_0011_0000_0000, // R9 clock rises
    19'b0001_101_0011_0000_1000, // R1 START mid-byte
    19'b1000_101_0011_1010_1000, // R8 clear without stop request
    19'b1000_101_0011_1101_1110, // R8 stop request without clear
    19'b0101_101_0011_1111_0011, // R5 recovery, R6 ack kept at 1
    19'b0101_101_0011_0000_0010, // R5 pulse ends
    19'b1001_001_1000_0000_0010, // R9 clock low in ack slot
    19'b1001_101_1000_0000_0010, // R9 clock high
    19'b0010_111_1000_0000_1010, // R2 STOP in ack slot
    19'b0110_111_1000_1110_0001, // R6 recovery writes ack 0
    19'b0100_111_0000_0000_0000, // R4 no fault
    19'b0011_011_0000_0000_0000, // R3
    19'b0011_111_0000_0000_0000, // R3
    19'b0011_101_0000_0000_0000, // R3 repeated START at boundary
    19'b0011_111_0000_0000_0000, // R3 STOP at boundary
    19'b1010_110_0000_1100_0100, // R10 stop request, no fault
    19'b1010_110_0000_0000_0100, // R10 holds, no idle pulse
    19'b0001_101_0101_0000_1100, // R1 fault with stop request stored
    19'b0110_101_0101_1110_0001  // R6 recovery clears both
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    check("R4 reset fault", {7'd0, fault_flag}, 8'd0);
    check("R4 reset status", status_code, 8'hF8);
    check("R4 reset release", {6'd0, line_release, shift_hold}, 8'd0);
    check("R4 reset regs", {5'd0, sto_req, ack_en, go_idle}, 8'd0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < NV; i++) begin
      logic [18:0] v;
      string tag;
      v = VEC[i];
      tag = $sformatf("R%0d row %0d", v[18:15], i);
      {scl_s, sda_s, frame_on} = v[14:12];
      bit_pos = v[11:8];
      {host_we, host_sto, host_clr, host_ack} = v[7:4];
      @(negedge clk);
      host_we = 1'b0;
      check({tag, " fault"}, {7'd0, fault_flag}, {7'd0, v[3]});
      check({tag, " status"}, status_code, v[3] ? 8'h00 : 8'hF8);
      check({tag, " sto"}, {7'd0, sto_req}, {7'd0, v[2]});
      check({tag, " ack"}, {7'd0, ack_en}, {7'd0, v[1]});
      check({tag, " idle"}, {7'd0, go_idle}, {7'd0, v[0]});
      check({tag, " R7 release"}, {6'd0, line_release, shift_hold}, {6'd0, v[3], v[3]});
    end
    // R4: reset while a fault is pending
    scl_s = 1'b1; sda_s = 1'b1; frame_on = 1'b1; bit_pos = 4'd2;
    @(negedge clk);
    sda_s = 1'b0;
    @(negedge clk);
    check("R1 directed fault", {7'd0, fault_flag}, 8'd1);
    rst_n = 1'b0;
    #1;
    check("R4 reset clears fault", {7'd0, fault_flag}, 8'd0);
    check("R4 reset status", status_code, 8'hF8);
    @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule